// File: doc/BRIEF.md
# Multi-Mode Programmable Delay Timer

This block produces a programmable time delay between an edge on a trigger input and a change on a main output. It counts a tick-enable, which stands in for a slow reference oscillator, rather than raw clock cycles, so the delay in seconds equals the selected tick count divided by the tick rate. A 3-bit select picks one of eight tick counts that follow a decade and sexagesimal pattern. At a 10 kHz tick the eight settings give 0.1 s, 1 s, 10 s, 0.1 min, 1 min, 10 min, 0.1 h and 1 h.

A 2-bit mode input picks one of four trigger policies. On-delay times from a rising edge. Off-delay times from a falling edge. Dual-delay times from both edges. Retriggerable one-shot gives a low pulse on the main output that every new rising edge stretches. One counter serves all four policies. The select value is captured at each start. The block drives the main output, its complement, and a busy flag that is high while a delay is being timed. A synchronous clear input aborts any delay and returns the output to its idle level.

The parameter `BASE_COUNT` (default 1000) scales the whole table. The counter width comes from it, and the default width is 26 bits.

Top module: `delay_timer`

## Requirements
- R1: With `sel_i` = 0..7 the delay lasts `BASE_COUNT` times 1, 10, 100, 60, 600, 6000, 3600 and 36000 ticks respectively. The value of `sel_i` is captured when a delay starts.
- R2: The counter advances only in cycles where `tick_i` is 1, so a gap in ticks lengthens the delay by the number of missing ticks. A trigger edge sampled at clock edge k starts timing at edge k+1, and the output changes at edge k+1+N when ticks arrive every cycle.
- R3: In on-delay mode (`mode_i`=00), a rising trigger starts timing. On completion `out_o` goes to 0.
- R4: In on-delay mode, a falling trigger aborts any timing in progress and sets `out_o` to 1 one cycle after the synchronised edge. No later completion occurs.
- R5: In off-delay mode (`mode_i`=01), a falling trigger starts timing and completion sets `out_o` to 1. A rising trigger aborts timing and sets `out_o` to 0 at once.
- R6: In dual-delay mode (`mode_i`=10), a rising edge starts an on-delay with target 0 and a falling edge starts an off-delay with target 1. Each new edge cancels the delay in progress, and `out_o` changes only when a delay completes.
- R7: In one-shot mode (`mode_i`=11), a rising edge sets `out_o` to 0 at once and starts timing. Completion sets `out_o` back to 1.
- R8: In one-shot mode, every rising edge restarts the full count, which stretches the low pulse. Falling edges change neither the output nor the timing.
- R9: `out_n_o` is always the complement of `out_o`. `busy_o` is 1 exactly while a delay is being timed.
- R10: After reset `out_o`=1 and `busy_o`=0. Holding `clr_i` high for a cycle aborts any delay and gives `out_o`=1 and `busy_o`=0 after the next edge.
- R11: Changing `sel_i` or `mode_i` while a delay is being timed does not alter its length or its target level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable that advances the delay counter |
| clr_i | input | 1 | Synchronous abort; returns output to idle |
| mode_i | input | 2 | 00 on-delay, 01 off-delay, 10 dual-delay, 11 one-shot |
| sel_i | input | 3 | Delay length select |
| trig_i | input | 1 | Trigger, synchronised internally |
| out_o | output | 1 | Main timed output |
| out_n_o | output | 1 | Complement of out_o |
| busy_o | output | 1 | High while a delay is being timed |

## Verification
A wrong count load or a wrong decrement shows up as a completion edge on `out_o` and a fall of `busy_o` at the wrong cycle. The bench therefore checks the cycles just before and just at each predicted completion. A stale target level or a missed abort shows up much later, as a spurious change at the point where the cancelled delay would have ended, so every abort and retrigger test also samples that point. A fault in edge handling appears two cycles after the trigger moves, where the immediate output change or the rise of `busy_o` is due.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    MODE_ON      = 2'b00,
    MODE_OFF     = 2'b01,
    MODE_DUAL    = 2'b10,
    MODE_ONESHOT = 2'b11
  } mode_e;

  // decade steps, then x60 and x3600 families
  function automatic int unsigned sel_to_ticks(input logic [2:0] sel,
                                               input int unsigned base);
    int unsigned mult;
    case (sel)
      3'd0:    mult = 1;
      3'd1:    mult = 10;
      3'd2:    mult = 100;
      3'd3:    mult = 60;
      3'd4:    mult = 600;
      3'd5:    mult = 6000;
      3'd6:    mult = 3600;
      default: mult = 36000;
    endcase
    return base * mult;
  endfunction

endpackage

// File: rtl/timer_edge.sv
module timer_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o,
  output logic fall_o
);
  logic trig_s, trig_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_s <= 1'b0;
      trig_d <= 1'b0;
    end else begin
      trig_s <= trig_i;
      trig_d <= trig_s;
    end
  end

  assign rise_o = trig_s & ~trig_d;
  assign fall_o = ~trig_s & trig_d;

  // R2: an edge is reported for exactly one cycle
  p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_single_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned BASE_COUNT = 1000,
  parameter int unsigned CNT_W      = 26
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [2:0] sel_i,
  output logic       done_o,
  output logic       busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [CNT_W-1:0] load_val;
  logic             last_tick;

  assign load_val  = CNT_W'(timer_pkg::sel_to_ticks(sel_i, BASE_COUNT));
  assign last_tick = active_q & tick_i & (cnt_q == CNT_W'(1));
  assign done_o    = last_tick;
  assign busy_o    = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= load_val;
      active_q <= 1'b1;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (active_q && tick_i) begin
      if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
      else                    cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  // R2: without a tick the count holds
  p_tick_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i && !start_i && !abort_i) |=> ($stable(cnt_q) && active_q));
  // R2: a running count never reaches zero
  p_no_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0));
  // R9: busy only rises on a start
  p_busy_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(start_i));

endmodule

// File: rtl/timer_mode_ctrl.sv
module timer_mode_ctrl
  import timer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  done_i,
  input  logic  clr_i,
  output logic  start_o,
  output logic  abort_o,
  output logic  out_o
);
  logic out_q, tgt_q, tgt_d;
  logic set_out, out_val;

  always_comb begin
    start_o = 1'b0;
    abort_o = 1'b0;
    set_out = 1'b0;
    out_val = 1'b1;
    tgt_d   = tgt_q;
    case (mode_i)
      MODE_ON: begin
        if (rise_i) begin
          start_o = 1'b1; tgt_d = 1'b0;
        end else if (fall_i) begin
          abort_o = 1'b1; set_out = 1'b1; out_val = 1'b1;
        end
      end
      MODE_OFF: begin
        if (fall_i) begin
          start_o = 1'b1; tgt_d = 1'b1;
        end else if (rise_i) begin
          abort_o = 1'b1; set_out = 1'b1; out_val = 1'b0;
        end
      end
      MODE_DUAL: begin
        if (rise_i) begin
          start_o = 1'b1; tgt_d = 1'b0;
        end else if (fall_i) begin
          start_o = 1'b1; tgt_d = 1'b1;
        end
      end
      MODE_ONESHOT: begin
        if (rise_i) begin
          start_o = 1'b1; tgt_d = 1'b1; set_out = 1'b1; out_val = 1'b0;
        end
      end
      default: ;
    endcase
    if (clr_i) begin
      start_o = 1'b0;
      abort_o = 1'b1;
      set_out = 1'b0;
      tgt_d   = tgt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b1;
      tgt_q <= 1'b1;
    end else begin
      tgt_q <= tgt_d;
      if (clr_i)                               out_q <= 1'b1;
      else if (set_out)                        out_q <= out_val;
      else if (done_i && !start_o && !abort_o) out_q <= tgt_q;
    end
  end

  assign out_o = out_q;

  // R8: one-shot falling edges leave the output alone
  p_ost_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && fall_i && !clr_i && !done_i) |=> $stable(out_q));
  // R6: in dual mode the output moves only on completion
  p_dual_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(out_q) && $past(mode_i) == MODE_DUAL && !$past(clr_i)) |-> $past(done_i));
  // R4: on-delay falling edge returns output high
  p_ond_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ON && fall_i) |=> out_q);
  // R7: one-shot rise drives output low
  p_ost_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ONESHOT && rise_i && !clr_i) |=> !out_q);

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int unsigned BASE_COUNT = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic [1:0] mode_i,
  input  logic [2:0] sel_i,
  input  logic       trig_i,
  output logic       out_o,
  output logic       out_n_o,
  output logic       busy_o
);
  localparam int unsigned MAX_TICKS = BASE_COUNT * 36000;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic rise, fall, start, abort, done, out_main;

  timer_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  timer_mode_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (timer_pkg::mode_e'(mode_i)),
    .rise_i  (rise),
    .fall_i  (fall),
    .done_i  (done),
    .clr_i   (clr_i),
    .start_o (start),
    .abort_o (abort),
    .out_o   (out_main)
  );

  timer_counter #(
    .BASE_COUNT (BASE_COUNT),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (start),
    .abort_i (abort),
    .sel_i   (sel_i),
    .done_o  (done),
    .busy_o  (busy_o)
  );

  assign out_o   = out_main;
  assign out_n_o = ~out_main;

  // R10: clear leaves the block idle
  p_clr_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (out_o && !busy_o));
  // R9: completion ends busy
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !start && !abort) |=> !busy_o);

endmodule

// File: tb/tb_delay_timer.sv
module tb_delay_timer;
  localparam int BASE = 2;
  localparam int WD   = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] sel = 3'd0;
  logic trig = 1'b0;
  logic out, out_n, busy;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int    at;
    bit    o;
    bit    b;
    string tag;
  } exp_t;
  exp_t q[$];

  delay_timer #(.BASE_COUNT(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clr_i(clr),
    .mode_i(mode), .sel_i(sel), .trig_i(trig),
    .out_o(out), .out_n_o(out_n), .busy_o(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nt(int s);
    int m[8] = '{1, 10, 100, 60, 600, 6000, 3600, 36000};
    return BASE * m[s];
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic expect_at(int at, bit o, bit b, string tag);
    q.push_back('{at, o, b, tag});
  endtask

  // monitor: compare at negedge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      if (q[0].at < cyc) chk(1'b0, {q[0].tag, " missed"}, cyc, q[0].at);
      else begin
        chk(out == q[0].o, {q[0].tag, " out"}, int'(out), int'(q[0].o));
        chk(busy == q[0].b, {q[0].tag, " busy"}, int'(busy), int'(q[0].b));
        chk(out_n == ~out, "R9 complement", int'(out_n), int'(~out));
      end
      void'(q.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > WD) begin
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    step(1);
  endtask

  task automatic set_trig(bit v, output int t);
    @(negedge clk);
    trig = v;
    t = cyc;
  endtask

  task automatic pulse_clr(output int c);
    @(negedge clk);
    clr = 1'b1;
    c = cyc;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    int t0, t1, tf, c, n;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(out == 1'b1, "R10 reset out", int'(out), 1);
    chk(out_n == 1'b0, "R10 reset out_n", int'(out_n), 0);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);

    // R1 R3: on-delay over all eight settings
    mode = 2'b00;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      n = nt(s);
      set_trig(1'b1, t0);
      expect_at(t0 + 2, 1, 1, "R3 start");
      expect_at(t0 + 1 + n, 1, 1, "R1 before end");
      expect_at(t0 + 2 + n, 0, 0, "R1 end");
      drain();
      set_trig(1'b0, t1);
      expect_at(t1 + 2, 1, 0, "R4 release");
      drain();
    end

    // R4: abort mid-delay
    sel = 3'd1; n = nt(1);
    set_trig(1'b1, t0);
    step(4);
    set_trig(1'b0, t1);
    expect_at(t1 + 1, 1, 1, "R4 busy before abort");
    expect_at(t1 + 2, 1, 0, "R4 abort");
    expect_at(t0 + 2 + n, 1, 0, "R4 no late completion");
    drain();

    // R5: off-delay
    mode = 2'b01; sel = 3'd0; n = nt(0);
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 0, 0, "R5 rise drives low");
    drain();
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 0, 1, "R5 start");
    expect_at(t0 + 2 + n, 1, 0, "R5 end");
    drain();
    sel = 3'd1; n = nt(1);
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 0, 0, "R5 rise low again");
    drain();
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 0, 1, "R5 start long");
    step(4);
    set_trig(1'b1, t1);
    expect_at(t1 + 2, 0, 0, "R5 abort");
    expect_at(t0 + 2 + n, 0, 0, "R5 no late completion");
    drain();

    // R6: dual-delay
    mode = 2'b10; sel = 3'd1; n = nt(1);
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 0, 1, "R6 off start no change");
    expect_at(t0 + 2 + n, 1, 0, "R6 off end");
    drain();
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 1, 1, "R6 on start no change");
    expect_at(t0 + 1 + n, 1, 1, "R6 before on end");
    expect_at(t0 + 2 + n, 0, 0, "R6 on end");
    drain();
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 0, 1, "R6 off start");
    step(5);
    set_trig(1'b1, t1);
    expect_at(t0 + 2 + n, 0, 1, "R6 cancelled off");
    expect_at(t1 + 2 + n, 0, 0, "R6 on end after cancel");
    drain();

    // R10 R8 R7: one-shot
    mode = 2'b11;
    pulse_clr(c);
    expect_at(c + 1, 1, 0, "R10 clr idle");
    drain();
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 1, 0, "R8 fall no effect");
    expect_at(t0 + 5, 1, 0, "R8 fall still idle");
    drain();
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 0, 1, "R7 pulse start");
    expect_at(t0 + 1 + n, 0, 1, "R7 before end");
    expect_at(t0 + 2 + n, 1, 0, "R7 pulse end");
    drain();
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 1, 0, "R8 fall idle");
    drain();
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 0, 1, "R7 retrig start");
    step(4);
    set_trig(1'b0, tf);
    expect_at(tf + 2, 0, 1, "R8 fall mid pulse");
    step(4);
    set_trig(1'b1, t1);
    expect_at(t0 + 2 + n, 0, 1, "R8 stretched");
    expect_at(t1 + 1 + n, 0, 1, "R8 before end");
    expect_at(t1 + 2 + n, 1, 0, "R8 end after retrig");
    drain();

    // R10: clear during one-shot pulse
    set_trig(1'b0, t0);
    drain();
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 0, 1, "R7 pulse for clr");
    step(4);
    pulse_clr(c);
    expect_at(c + 1, 1, 0, "R10 clr ends pulse");
    expect_at(t0 + 2 + n, 1, 0, "R10 no completion");
    drain();

    // R2: tick gap stretches delay
    mode = 2'b00;
    set_trig(1'b0, t0);
    expect_at(t0 + 2, 1, 0, "R4 fall idle");
    drain();
    set_trig(1'b1, t0);
    expect_at(t0 + 2, 1, 1, "R2 start");
    step(5);
    tick = 1'b0;
    step(10);
    tick = 1'b1;
    expect_at(t0 + 2 + n + 9, 1, 1, "R2 gated before end");
    expect_at(t0 + 2 + n + 10, 0, 0, "R2 gated end");
    drain();
    set_trig(1'b0, t0);
    drain();

    // R11: select and mode changes mid-delay ignored
    set_trig(1'b1, t0);
    step(4);
    sel = 3'd0;
    mode = 2'b11;
    expect_at(t0 + 10, 1, 1, "R11 settings change ignored");
    expect_at(t0 + 1 + n, 1, 1, "R11 before end");
    expect_at(t0 + 2 + n, 0, 0, "R11 end");
    drain();
    mode = 2'b00; sel = 3'd1;

    // R10: clear during on-delay
    set_trig(1'b0, t0);
    drain();
    set_trig(1'b1, t0);
    step(4);
    pulse_clr(c);
    expect_at(c + 1, 1, 0, "R10 clr abort");
    expect_at(t0 + 2 + n, 1, 0, "R10 no late completion");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule